// File: doc/BRIEF.md
# ECC Error DIMM Locator

This block turns a corrected-error report into a physical location. A request carries a signed syndrome code, the quadword beat of the faulting address (physical address bits [5:4]), a bank-hit flag and the bank id. For a single-bit error the block works out which bit of the 576-bit line failed, looks that bit up in a loaded table of 2-bit DIMM fields, and returns the DIMM index within the controller together with the line bit position. For a multi-bit error it returns the first DIMM of the bank group and raises a flag, meaning that every DIMM in that group is suspect. Requests it cannot resolve are flagged as unknown.

The block holds two tables, one for symmetric and one for asymmetric layouts. Software fills them through a byte-wide write port before use. A configuration input that travels with each request chooses between them. One request can be accepted each cycle, and the answer appears two clock edges later.

Top module: `ecc_dimm_locator`

## Requirements
- R1: While reset is held and until the first request completes, rsp_valid, rsp_unknown, rsp_multi, rsp_dimm and rsp_bitpos are all 0.
- R2: A request sampled at clock edge N yields rsp_valid high after edge N+2 for exactly one cycle. rsp_valid is low in every cycle that no request feeds.
- R3: If req_bank_hit is 0, or the syndrome (9-bit two's complement) is below -1 or above 144, the response has rsp_unknown=1, rsp_multi=0, rsp_dimm=0 and rsp_bitpos=0.
- R4: A syndrome of -1 with a bank hit gives rsp_multi=1, rsp_unknown=0, rsp_bitpos=0, and rsp_dimm set to the first DIMM of the group.
- R5: A single-bit syndrome s is renumbered to bus order as follows: s+16 when s<128, s-137 when 128<=s<144, and s-143 when s=144.
- R6: rsp_bitpos = (3 - req_qw) * 144 + renumbered code. If this value falls outside 0..575, the response is unknown as in R3.
- R7: The table position is t = 575 - rsp_bitpos. The table byte is entry t>>2. Slot k = t&3 occupies byte bits [7-2k:6-2k]. Only the low bit of that field (byte bit 6-2k) is the DIMM offset.
- R8: The first DIMM of the group is ((bank id mod 4) mod 2) * 4. A single-bit response gives rsp_dimm = first DIMM + offset.
- R9: When req_symmetric is 1 the lookup uses map 0. Otherwise it uses map 1.
- R10: A write with tbl_wr_en=1 stores tbl_wr_data at entry tbl_wr_addr (0..143) of the map picked by tbl_wr_sel (0 or 1). The other map is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_wr_en | input | 1 | Table byte write strobe |
| tbl_wr_sel | input | 1 | Map chosen for the write (0 symmetric, 1 asymmetric) |
| tbl_wr_addr | input | 8 | Table byte entry, 0..143 |
| tbl_wr_data | input | 8 | Four packed 2-bit DIMM fields |
| req_valid | input | 1 | Request strobe |
| req_syndrome | input | 9 | Signed syndrome code |
| req_qw | input | 2 | Quadword beat, physical address bits [5:4] |
| req_bank_hit | input | 1 | A bank decoded the address |
| req_bank_id | input | 4 | Id of the decoding bank |
| req_symmetric | input | 1 | Layout is symmetric: use map 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_unknown | output | 1 | Location could not be resolved |
| rsp_multi | output | 1 | Multi-bit error: the whole group is implicated |
| rsp_dimm | output | 3 | DIMM index within the controller |
| rsp_bitpos | output | 10 | Failing bit position within the line |

## Verification
Random syndromes from -3 to 150 are applied with random beats, bank ids and map selections against randomly filled tables. This exercises all three renumbering bands, both group bases and both maps, and each one is distinguished by the DIMM offset bit it reads. Directed cases sit on the band edges (127, 128, 136, 137, 143, 144), on the just-outside codes -2 and 145, and on beat 3 with codes that produce a negative line position. These separate off-by-one band limits and bad sign handling from correct results. A single table byte is then written with one-hot field patterns to pin down the slot-to-bit order. The opposite map is rewritten afterwards to show that the selected map is unaffected.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;
  localparam int BEATS      = 4;
  localparam int BEAT_BITS  = 144;
  localparam int LINE_BITS  = BEATS * BEAT_BITS;
  localparam int FIELDS_PER_BYTE = 4;
  localparam int MAP_BYTES  = LINE_BITS / FIELDS_PER_BYTE;
  localparam int NMAPS      = 2;
  localparam int SYN_W      = 9;
  localparam int POS_W      = $clog2(LINE_BITS);
  localparam int IDX_W      = $clog2(MAP_BYTES);
  localparam int LPOS_W     = POS_W + 2;

  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_MULTI  = 2'd1,
    CLS_BAD    = 2'd2
  } syn_class_e;
endpackage

// File: rtl/ecc_loc_rst_sync.sv
module ecc_loc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/ecc_loc_remap.sv
module ecc_loc_remap
  import ecc_loc_pkg::*;
(
  input  logic signed [SYN_W-1:0]  syn,
  input  logic [1:0]               beat,
  output syn_class_e               cls,
  output logic signed [LPOS_W-1:0] line_pos
);
  localparam int LOW_BAND  = BEAT_BITS - 16;
  localparam int HIGH_BAND = BEAT_BITS;
  localparam int EXTRA_END = BEAT_BITS + 3;

  int si, ri, pi;

  always_comb begin
    si = int'(syn);
    if (si < LOW_BAND)       ri = si + 16;
    else if (si < HIGH_BAND) ri = si - (HIGH_BAND - 7);
    else if (si < EXTRA_END) ri = si - (EXTRA_END - 4);
    else                     ri = si - EXTRA_END;
    pi = (BEATS - 1 - int'(beat)) * BEAT_BITS + ri;

    if (si == -1)                         cls = CLS_MULTI;
    else if (si < -1 || si > HIGH_BAND)   cls = CLS_BAD;
    else if (pi < 0 || pi >= LINE_BITS)   cls = CLS_BAD;
    else                                  cls = CLS_SINGLE;

    line_pos = LPOS_W'(pi);
  end
endmodule

// File: rtl/ecc_loc_map_table.sv
module ecc_loc_map_table
  import ecc_loc_pkg::*;
(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [MAP_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < IDX_W'(MAP_BYTES))) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    if (rd_addr < IDX_W'(MAP_BYTES)) rd_data = mem[rd_addr];
    else                             rd_data = '0;
  end
endmodule

// File: rtl/ecc_loc_slot_pick.sv
module ecc_loc_slot_pick (
  input  logic [7:0] byte_i,
  input  logic [1:0] slot,
  output logic       offset
);
  always_comb begin
    offset = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (slot == 2'(k)) offset = byte_i[6 - 2*k];
    end
  end
endmodule

// File: rtl/ecc_dimm_locator.sv
module ecc_dimm_locator
  import ecc_loc_pkg::*;
#(
  parameter int BANK_ID_W       = 4,
  parameter int BANKS_PER_CTRL  = 4,
  parameter int GROUPS          = 2,
  parameter int DIMMS_PER_GROUP = 4,
  localparam int DIMM_W = $clog2(GROUPS * DIMMS_PER_GROUP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_wr_en,
  input  logic                   tbl_wr_sel,
  input  logic [IDX_W-1:0]       tbl_wr_addr,
  input  logic [7:0]             tbl_wr_data,
  input  logic                   req_valid,
  input  logic signed [SYN_W-1:0] req_syndrome,
  input  logic [1:0]             req_qw,
  input  logic                   req_bank_hit,
  input  logic [BANK_ID_W-1:0]   req_bank_id,
  input  logic                   req_symmetric,
  output logic                   rsp_valid,
  output logic                   rsp_unknown,
  output logic                   rsp_multi,
  output logic [DIMM_W-1:0]      rsp_dimm,
  output logic [POS_W-1:0]       rsp_bitpos
);
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  typedef struct packed {
    logic             valid;
    logic             unknown;
    logic             multi;
    logic [IDX_W-1:0] idx;
    logic [1:0]       slot;
    logic [GRP_W-1:0] grp;
    logic             sym;
    logic [POS_W-1:0] pos;
  } stage1_t;

  logic rst_q;
  ecc_loc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // ---------------- stage 1: classify, renumber, locate ----------------
  syn_class_e               cls;
  logic signed [LPOS_W-1:0] line_pos;

  ecc_loc_remap u_remap (
    .syn(req_syndrome), .beat(req_qw), .cls(cls), .line_pos(line_pos)
  );

  stage1_t s1_d, s1_q;
  int      tpos;

  always_comb begin
    tpos       = LINE_BITS - 1 - int'(line_pos);
    s1_d       = '0;
    s1_d.valid = req_valid;
    s1_d.sym   = req_symmetric;
    s1_d.grp   = GRP_W'((int'(req_bank_id) % BANKS_PER_CTRL) % GROUPS);
    if (!req_bank_hit || cls == CLS_BAD) begin
      s1_d.unknown = 1'b1;
      s1_d.grp     = '0;
    end else if (cls == CLS_MULTI) begin
      s1_d.multi = 1'b1;
    end else begin
      s1_d.idx  = IDX_W'(tpos >> 2);
      s1_d.slot = 2'(tpos & 3);
      s1_d.pos  = POS_W'(int'(line_pos));
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_q <= '0;
    end else begin
      s1_q.valid <= s1_d.valid;
      if (req_valid) begin
        s1_q.unknown <= s1_d.unknown;
        s1_q.multi   <= s1_d.multi;
        s1_q.idx     <= s1_d.idx;
        s1_q.slot    <= s1_d.slot;
        s1_q.grp     <= s1_d.grp;
        s1_q.sym     <= s1_d.sym;
        s1_q.pos     <= s1_d.pos;
      end
    end
  end

  // ---------------- tables ----------------
  logic [7:0] rd_bytes [NMAPS];

  for (genvar g = 0; g < NMAPS; g++) begin : g_map
    ecc_loc_map_table u_tbl (
      .clk     (clk),
      .wr_en   (tbl_wr_en && (tbl_wr_sel == 1'(g))),
      .wr_addr (tbl_wr_addr),
      .wr_data (tbl_wr_data),
      .rd_addr (s1_q.idx),
      .rd_data (rd_bytes[g])
    );
  end

  // ---------------- stage 2: pick field, form response ----------------
  logic              offset;
  logic [7:0]        sel_byte;
  logic              v2_d, unk2_d, multi2_d;
  logic [DIMM_W-1:0] dimm2_d;
  logic [POS_W-1:0]  pos2_d;
  int                base;

  assign sel_byte = s1_q.sym ? rd_bytes[0] : rd_bytes[1];

  ecc_loc_slot_pick u_pick (.byte_i(sel_byte), .slot(s1_q.slot), .offset(offset));

  always_comb begin
    base     = int'(s1_q.grp) * DIMMS_PER_GROUP;
    v2_d     = s1_q.valid;
    unk2_d   = s1_q.unknown;
    multi2_d = s1_q.multi;
    if (s1_q.unknown) begin
      dimm2_d = '0;
      pos2_d  = '0;
    end else if (s1_q.multi) begin
      dimm2_d = DIMM_W'(base);
      pos2_d  = '0;
    end else begin
      dimm2_d = DIMM_W'(base + int'(offset));
      pos2_d  = s1_q.pos;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid   <= 1'b0;
      rsp_unknown <= 1'b0;
      rsp_multi   <= 1'b0;
      rsp_dimm    <= '0;
      rsp_bitpos  <= '0;
    end else begin
      rsp_valid <= v2_d;
      if (s1_q.valid) begin
        rsp_unknown <= unk2_d;
        rsp_multi   <= multi2_d;
        rsp_dimm    <= dimm2_d;
        rsp_bitpos  <= pos2_d;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |-> ##2 rsp_valid);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |-> ##2 !rsp_valid);

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> !(rsp_unknown && rsp_multi));

  a_r3_unknown_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && rsp_unknown) |-> (rsp_dimm == '0 && rsp_bitpos == '0));

  a_r4_multi_group_base: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && rsp_multi) |->
      (rsp_bitpos == '0 && (int'(rsp_dimm) % DIMMS_PER_GROUP) == 0));

  a_r6_bitpos_in_line: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> (int'(rsp_bitpos) < LINE_BITS));

  a_r8_offset_one_bit: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && !rsp_unknown && !rsp_multi) |->
      ((int'(rsp_dimm) % DIMMS_PER_GROUP) < 2));
endmodule

// File: tb/sim_ecc_dimm_locator.sv
module sim_ecc_dimm_locator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tbl_wr_en, tbl_wr_sel;
  logic [7:0] tbl_wr_addr, tbl_wr_data;
  logic       req_valid;
  logic signed [8:0] req_syndrome;
  logic [1:0] req_qw;
  logic       req_bank_hit;
  logic [3:0] req_bank_id;
  logic       req_symmetric;
  logic       rsp_valid, rsp_unknown, rsp_multi;
  logic [2:0] rsp_dimm;
  logic [9:0] rsp_bitpos;

  int tests = 0;
  int failed = 0;
  bit done = 0;
  logic [7:0] m0 [144];
  logic [7:0] m1 [144];

  always #5 clk = ~clk;

  ecc_dimm_locator u0 (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .req_valid(req_valid), .req_syndrome(req_syndrome), .req_qw(req_qw),
    .req_bank_hit(req_bank_hit), .req_bank_id(req_bank_id),
    .req_symmetric(req_symmetric),
    .rsp_valid(rsp_valid), .rsp_unknown(rsp_unknown), .rsp_multi(rsp_multi),
    .rsp_dimm(rsp_dimm), .rsp_bitpos(rsp_bitpos)
  );

  // expected {unknown, multi, dimm[2:0], bitpos[9:0]}
  function automatic logic [14:0] expect_rsp(int syn, int qw, bit hit, int bank, bit sym);
    int rem, pos, t, k, off, first;
    logic [7:0] b;
    first = ((bank % 4) % 2) * 4;
    if (!hit || syn < -1 || syn > 144) return {1'b1, 1'b0, 3'd0, 10'd0};
    if (syn == -1) return {1'b0, 1'b1, 3'(first), 10'd0};
    if (syn < 128)      rem = syn + 16;
    else if (syn < 144) rem = syn - 137;
    else                rem = syn - 143;
    pos = (3 - qw) * 144 + rem;
    if (pos < 0 || pos > 575) return {1'b1, 1'b0, 3'd0, 10'd0};
    t = 575 - pos;
    k = t % 4;
    b = sym ? m0[t / 4] : m1[t / 4];
    off = int'(b[6 - 2*k]);
    return {1'b0, 1'b0, 3'(first + off), 10'(pos)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbl_write(bit sel, int addr, logic [7:0] data);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_sel = sel; tbl_wr_addr = 8'(addr); tbl_wr_data = data;
    if (sel) m1[addr] = data; else m0[addr] = data;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic lookup(string req, int syn, int qw, bit hit, int bank, bit sym);
    logic [14:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_syndrome = 9'(syn); req_qw = 2'(qw);
    req_bank_hit = hit; req_bank_id = 4'(bank); req_symmetric = sym;
    exp = expect_rsp(syn, qw, hit, bank, sym);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R2 pending"}, 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check({req, " R2 valid"}, 32'(rsp_valid), 32'd1);
    check(req, 32'({rsp_unknown, rsp_multi, rsp_dimm, rsp_bitpos}), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; tbl_wr_en = 0; tbl_wr_sel = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
    req_valid = 0; req_syndrome = 0; req_qw = 0; req_bank_hit = 0; req_bank_id = 0;
    req_symmetric = 0;
    repeat (4) @(negedge clk);
    check("R1 reset state", 32'({rsp_valid, rsp_unknown, rsp_multi, rsp_dimm, rsp_bitpos}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'({rsp_valid, rsp_unknown, rsp_multi, rsp_dimm, rsp_bitpos}), 32'd0);

    for (int i = 0; i < 144; i++) begin
      tbl_write(1'b0, i, 8'($urandom));
      tbl_write(1'b1, i, 8'($urandom));
    end

    // R5 band edges
    lookup("R5 code 0", 0, 0, 1, 0, 1);
    lookup("R5 code 127", 127, 1, 1, 1, 0);
    lookup("R5 code 128", 128, 0, 1, 2, 1);
    lookup("R5 code 143", 143, 2, 1, 3, 0);
    lookup("R5 code 144", 144, 1, 1, 5, 1);
    // R6 negative / edge positions on beat 3
    lookup("R6 code 136 beat3 negative", 136, 3, 1, 1, 1);
    lookup("R6 code 128 beat3 negative", 128, 3, 1, 0, 0);
    lookup("R6 code 137 beat3 pos 0", 137, 3, 1, 0, 1);
    lookup("R6 code 127 beat0 top", 127, 0, 1, 1, 1);
    // R3 rejection
    lookup("R3 code -2", -2, 0, 1, 0, 1);
    lookup("R3 code 145", 145, 0, 1, 0, 1);
    lookup("R3 code 255", 255, 2, 1, 3, 0);
    lookup("R3 no bank hit", 10, 1, 0, 1, 1);
    lookup("R3 multi no hit", -1, 0, 0, 1, 1);
    // R4 / R8 multi-bit
    lookup("R4 multi bank0", -1, 2, 1, 0, 1);
    lookup("R4 R8 multi bank1", -1, 0, 1, 1, 0);
    lookup("R4 R8 multi bank6", -1, 1, 1, 6, 1);
    lookup("R8 bank 7 single", 20, 2, 1, 7, 0);

    // R7 slot order: pos 0 -> t 575 -> entry 143 slot 3 -> bit 0
    tbl_write(1'b0, 143, 8'h01);
    lookup("R7 slot3 bit0 set", 137, 3, 1, 0, 1);
    check("R7 slot3 dimm", 32'(rsp_dimm), 32'd1);
    tbl_write(1'b0, 143, 8'hFE);
    lookup("R7 slot3 bit0 clear", 137, 3, 1, 1, 1);
    check("R7 slot3 dimm grp1", 32'(rsp_dimm), 32'd4);
    // pos 3 -> t 572 -> entry 143 slot 0 -> bit 6 ; code 140 beat3 gives rem 3
    tbl_write(1'b0, 143, 8'h40);
    lookup("R7 slot0 bit6", 140, 3, 1, 0, 1);
    check("R7 slot0 dimm", 32'(rsp_dimm), 32'd1);
    // R10 / R9: other map rewrite must not disturb map 0
    tbl_write(1'b1, 143, 8'h00);
    lookup("R10 map0 kept", 140, 3, 1, 0, 1);
    check("R10 map0 dimm", 32'(rsp_dimm), 32'd1);
    lookup("R9 map1 chosen", 140, 3, 1, 0, 0);
    check("R9 map1 dimm", 32'(rsp_dimm), 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int syn;
      syn = int'($urandom_range(153)) - 3;
      lookup("R5 R6 R7 R8 R9 random", syn, int'($urandom_range(3)),
             ($urandom_range(15) != 0), int'($urandom_range(15)), 1'($urandom));
    end

    @(negedge clk);
    check("R2 idle after traffic", 32'(rsp_valid), 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule